// File: doc/BRIEF.md
# Nesting Interrupt Controller with Status Stack

This block arbitrates three external interrupt request lines for a small fixed-point core. Each line is active low. Each line can be set to sense a falling edge, which is latched, or a low level, which is not latched. Software can also raise or cancel a pending request through a write-only force/clear port. A mask register and a global enable decide which pending requests may be taken. The highest-numbered eligible line always wins.

When a request is accepted, the block pulses an acknowledge for one clock and drives a vector address, equal to four times the line number, for the program counter. In the same clock it pushes one entry onto a hardware stack. The entry holds the arithmetic status word and the mode status word supplied by the core, the current mask, and the level currently in service. A return strobe pops the top entry. The two status words are presented back to the core with a one-clock valid, and the mask and the in-service level are restored inside the block.

A configuration bit selects one of two service disciplines. In nested mode, a request preempts only a lower-priority service. In one-at-a-time mode, no request is taken while any service is open. A separate input decides whether lines 0 and 1 act as interrupt inputs or are lent to a serial port.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, ack, vecAddr, inService, stackDepth, maskOut, restoreValid, ovfFlag and udfFlag are all zero. All lines are in level mode and the one-at-a-time discipline is selected.
- R2: Priority is fixed: line 2 is highest and line 0 is lowest. A line driven low in the cycle before clock edge N is seen at edge N. If it is eligible, ack is high for exactly one clock after edge N+1, with vecAddr equal to the line number times 4. inService then reads the line number plus 1.
- R3: In edge mode (cfgEdge bit = 1), a falling edge leaves the request pending after the line returns high. The pending state is cleared when that request is accepted.
- R4: In level mode (cfgEdge bit = 0), a request is pending only while its line is low. A low pulse that is masked while it lasts leaves nothing pending once the line is back high.
- R5: A pending request is accepted only when its maskOut bit is 1 and intEnable is 1.
- R6: When pinsAvail is 0, lines 0 and 1 cause no request. Line 2 is unaffected.
- R7: A forceClrData write sets pending for each line whose bit in [2:0] is 1, and cancels pending for each line whose bit in [5:3] is 1. If both bits are written for the same line, cancel wins.
- R8: With cfgNest = 1, a request is accepted during a service only if its line number plus 1 is strictly greater than inService.
- R9: With cfgNest = 0, no request is accepted while inService is nonzero.
- R10: On acceptance, one entry {arithStat, modeStat, mask, inService} is pushed and stackDepth rises by 1. The default stack holds STACK_D = 7 entries.
- R11: A clock edge with rtiStrobe high and a non-empty stack pops the top entry. restoreArith and restoreMode show the saved words with restoreValid high for one clock, and maskOut and inService return to their saved values. No request is accepted in that clock.
- R12: A push when stackDepth equals STACK_D sets ovfFlag, which stays set until reset. The push is discarded, but the request is still acknowledged.
- R13: A return strobe with an empty stack sets udfFlag, which stays set until reset. stackDepth stays 0 and restoreValid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLineN | input | 3 | Request lines, active low |
| pinsAvail | input | 1 | 1 = lines 0 and 1 act as interrupt inputs |
| intEnable | input | 1 | Global interrupt enable |
| cfgWe | input | 1 | Write strobe for the sense and discipline settings |
| cfgEdge | input | 3 | Per line: 1 = falling edge, 0 = low level |
| cfgNest | input | 1 | 1 = nested discipline, 0 = one at a time |
| forceClrWe | input | 1 | Write strobe for force/clear |
| forceClrData | input | 6 | [2:0] force bits, [5:3] cancel bits |
| maskWe | input | 1 | Mask write strobe |
| maskData | input | 3 | New mask value |
| arithStat | input | STAT_W | Arithmetic status word to save |
| modeStat | input | STAT_W | Mode status word to save |
| rtiStrobe | input | 1 | Return-from-service strobe |
| ack | output | 1 | One-clock acceptance pulse |
| vecAddr | output | VEC_W | Vector of the last accepted line |
| inService | output | 2 | Current service level, 0 = none |
| stackDepth | output | clog2(STACK_D+1) | Stack entries in use |
| maskOut | output | 3 | Current mask |
| restoreValid | output | 1 | Restored status words are valid |
| restoreArith | output | STAT_W | Restored arithmetic status |
| restoreMode | output | STAT_W | Restored mode status |
| ovfFlag | output | 1 | Sticky stack overflow |
| udfFlag | output | 1 | Sticky stack underflow |

## Verification
Arbitration is driven from a table of line patterns: single lines, pairs, and all three at once. These are crossed with partial masks, a cleared enable, and the serial-port setting of pinsAvail, so that picking the highest line cannot be confused with picking the first one seen or any one unmasked. A stair of three nested entries separates strict preemption from equal-priority re-entry. The same stair, run on a second copy with a two-entry stack, reaches overflow and later underflow. Masked pulses in the two sense modes show the difference between latched and unlatched requests. Force and cancel writes, including a simultaneous pair, show which one takes precedence.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC   = 3;
  localparam int LVL_W     = $clog2(NUM_SRC + 1);
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int VEC_SHIFT = 2;

  typedef struct packed {
    logic               push;
    logic               pop;
    logic [NUM_SRC-1:0] clrPend;
    logic [LVL_W-1:0]   newLvl;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int STACK_D = 7,
  parameter int DEPTH_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqLineN,
  input  logic                 pinsAvail,
  input  logic                 cfgWe,
  input  logic [NUM_SRC-1:0]   cfgEdge,
  input  logic                 cfgNest,
  input  logic                 forceClrWe,
  input  logic [2*NUM_SRC-1:0] forceClrData,
  input  logic                 maskWe,
  input  logic [NUM_SRC-1:0]   maskData,
  input  logic [STAT_W-1:0]    arithStat,
  input  logic [STAT_W-1:0]    modeStat,
  input  ctrlStrobe_t          strb,
  output logic [NUM_SRC-1:0]   pendVec,
  output logic [NUM_SRC-1:0]   maskOut,
  output logic                 nestMode,
  output logic [LVL_W-1:0]     curLvl,
  output logic [DEPTH_W-1:0]   depth,
  output logic                 restoreValid,
  output logic [STAT_W-1:0]    restoreArith,
  output logic [STAT_W-1:0]    restoreMode,
  output logic                 ovfFlag,
  output logic                 udfFlag
);
  localparam int ENT_W = 2 * STAT_W + NUM_SRC + LVL_W;
  localparam int MEM_N = 1 << DEPTH_W;
  localparam logic [DEPTH_W-1:0] FULL_CNT = DEPTH_W'(STACK_D);

  logic [NUM_SRC-1:0] lineQ, latchQ, edgeSelQ, availMask;
  logic [NUM_SRC-1:0] fallSeen, levelLow, setBits, clrBits;
  logic [DEPTH_W-1:0] topIdx;
  logic [ENT_W-1:0]   stackMem [MEM_N];
  logic [ENT_W-1:0]   topEnt, pushEnt;
  logic               stackFull, stackEmpty;

  // lines 0..NUM_SRC-2 may be lent to a serial port
  always_comb begin
    availMask = '1;
    for (int i = 0; i < NUM_SRC - 1; i++) availMask[i] = pinsAvail;
  end

  assign fallSeen = lineQ & ~irqLineN & availMask;
  assign levelLow = ~lineQ & ~edgeSelQ & availMask;
  assign pendVec  = latchQ | levelLow;

  assign setBits = (fallSeen & edgeSelQ)
                 | (forceClrWe ? forceClrData[NUM_SRC-1:0] : '0);
  assign clrBits = (forceClrWe ? forceClrData[2*NUM_SRC-1:NUM_SRC] : '0)
                 | strb.clrPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ    <= '1;
      latchQ   <= '0;
      edgeSelQ <= '0;
      nestMode <= 1'b0;
    end else begin
      lineQ  <= irqLineN;
      latchQ <= (latchQ | setBits) & ~clrBits;
      if (cfgWe) begin
        edgeSelQ <= cfgEdge;
        nestMode <= cfgNest;
      end
    end
  end

  // status stack
  assign stackFull  = (depth == FULL_CNT);
  assign stackEmpty = (depth == '0);
  assign topIdx     = depth - 1'b1;
  assign topEnt     = stackMem[topIdx];
  assign pushEnt    = {arithStat, modeStat, maskOut, curLvl};

  always_ff @(posedge clk) begin
    if (strb.push && !stackFull) stackMem[depth] <= pushEnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth        <= '0;
      curLvl       <= '0;
      maskOut      <= '0;
      restoreValid <= 1'b0;
      restoreArith <= '0;
      restoreMode  <= '0;
      ovfFlag      <= 1'b0;
      udfFlag      <= 1'b0;
    end else begin
      restoreValid <= 1'b0;
      if (maskWe) maskOut <= maskData;
      if (strb.push) begin
        curLvl <= strb.newLvl;
        if (stackFull) ovfFlag <= 1'b1;
        else           depth   <= depth + 1'b1;
      end else if (strb.pop) begin
        if (stackEmpty) begin
          udfFlag <= 1'b1;
        end else begin
          depth        <= topIdx;
          curLvl       <= topEnt[LVL_W-1:0];
          maskOut      <= topEnt[LVL_W +: NUM_SRC];
          restoreMode  <= topEnt[LVL_W + NUM_SRC +: STAT_W];
          restoreArith <= topEnt[LVL_W + NUM_SRC + STAT_W +: STAT_W];
          restoreValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic [NUM_SRC-1:0] maskVec,
  input  logic               intEnable,
  input  logic               nestMode,
  input  logic [LVL_W-1:0]   curLvl,
  input  logic               rtiStrobe,
  output ctrlStrobe_t        strb,
  output logic               ack,
  output logic [VEC_W-1:0]   vecAddr
);
  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   winIdx;
  logic [LVL_W-1:0]   winLvl;
  logic               winValid, allowed, take;

  // later (higher) index overrides: fixed priority, top line wins
  always_comb begin
    eligible = pendVec & maskVec & {NUM_SRC{intEnable}};
    winValid = 1'b0;
    winIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i]) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign winLvl  = LVL_W'(winIdx) + 1'b1;
  assign allowed = nestMode ? (winLvl > curLvl) : (curLvl == '0);
  assign take    = winValid && allowed && !rtiStrobe;

  always_comb begin
    strb.push    = take;
    strb.pop     = rtiStrobe;
    strb.newLvl  = winLvl;
    strb.clrPend = '0;
    if (take) strb.clrPend[winIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ack     <= 1'b0;
      vecAddr <= '0;
    end else begin
      ack <= take;
      if (take) vecAddr <= VEC_W'(winIdx) << VEC_SHIFT;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int STACK_D = 7,
  parameter int VEC_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2:0]                   irqLineN,
  input  logic                         pinsAvail,
  input  logic                         intEnable,
  input  logic                         cfgWe,
  input  logic [2:0]                   cfgEdge,
  input  logic                         cfgNest,
  input  logic                         forceClrWe,
  input  logic [5:0]                   forceClrData,
  input  logic                         maskWe,
  input  logic [2:0]                   maskData,
  input  logic [STAT_W-1:0]            arithStat,
  input  logic [STAT_W-1:0]            modeStat,
  input  logic                         rtiStrobe,
  output logic                         ack,
  output logic [VEC_W-1:0]             vecAddr,
  output logic [1:0]                   inService,
  output logic [$clog2(STACK_D+1)-1:0] stackDepth,
  output logic [2:0]                   maskOut,
  output logic                         restoreValid,
  output logic [STAT_W-1:0]            restoreArith,
  output logic [STAT_W-1:0]            restoreMode,
  output logic                         ovfFlag,
  output logic                         udfFlag
);
  localparam int DEPTH_W = $clog2(STACK_D + 1);

  ctrlStrobe_t        strb;
  logic [NUM_SRC-1:0] pendVec;
  logic               nestMode;

  irq_nest_dp #(.STAT_W(STAT_W), .STACK_D(STACK_D), .DEPTH_W(DEPTH_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqLineN(irqLineN), .pinsAvail(pinsAvail),
    .cfgWe(cfgWe), .cfgEdge(cfgEdge), .cfgNest(cfgNest),
    .forceClrWe(forceClrWe), .forceClrData(forceClrData),
    .maskWe(maskWe), .maskData(maskData),
    .arithStat(arithStat), .modeStat(modeStat), .strb(strb),
    .pendVec(pendVec), .maskOut(maskOut), .nestMode(nestMode),
    .curLvl(inService), .depth(stackDepth),
    .restoreValid(restoreValid), .restoreArith(restoreArith),
    .restoreMode(restoreMode), .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  irq_nest_arb #(.VEC_W(VEC_W)) u_arb (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .maskVec(maskOut),
    .intEnable(intEnable), .nestMode(nestMode), .curLvl(inService),
    .rtiStrobe(rtiStrobe), .strb(strb), .ack(ack), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int STACK_D = 7,
  parameter int VEC_W   = 8,
  parameter int DEPTH_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               ack,
  input logic [VEC_W-1:0]   vecAddr,
  input logic               intEnable,
  input logic               rtiStrobe,
  input logic               nestMode,
  input logic [1:0]         inService,
  input logic [DEPTH_W-1:0] stackDepth,
  input logic               restoreValid,
  input logic               ovfFlag,
  input logic               udfFlag
);
  localparam logic [DEPTH_W-1:0] FULL_CNT = DEPTH_W'(STACK_D);

  p_vec_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> vecAddr[1:0] == 2'b00);

  p_enable_needed_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ack) |-> $past(intEnable));

  p_one_at_a_time_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ack && !$past(nestMode)) |-> $past(inService) == 2'd0);

  p_push_grows_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ack && $past(stackDepth) != FULL_CNT)
      |-> stackDepth == DEPTH_W'($past(stackDepth) + 1'b1));

  p_pop_shrinks_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rtiStrobe) && $past(stackDepth) != '0)
      |-> (restoreValid && stackDepth == DEPTH_W'($past(stackDepth) - 1'b1)));

  p_no_ack_on_return_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rtiStrobe)) |-> !ack);

  p_full_discard_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ack && $past(stackDepth) == FULL_CNT)
      |-> (stackDepth == FULL_CNT && ovfFlag));

  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ovfFlag)) |-> ovfFlag);

  p_udf_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(udfFlag)) |-> udfFlag);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
  .STACK_D(STACK_D), .VEC_W(VEC_W), .DEPTH_W($clog2(STACK_D + 1))
) u_chk (
  .clk(clk), .rstN(rstN), .ack(ack), .vecAddr(vecAddr),
  .intEnable(intEnable), .rtiStrobe(rtiStrobe), .nestMode(nestMode),
  .inService(inService), .stackDepth(stackDepth),
  .restoreValid(restoreValid), .ovfFlag(ovfFlag), .udfFlag(udfFlag)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  // 125 MHz: 8 time-unit period
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [2:0] irqLineN;
  logic       pinsAvail, intEnable, cfgWe, cfgNest, forceClrWe, maskWe, rtiStrobe;
  logic [2:0] cfgEdge, maskData;
  logic [5:0] forceClrData;
  logic [7:0] arithStat, modeStat;

  logic       ack, restoreValid, ovfFlag, udfFlag;
  logic [7:0] vecAddr, restoreArith, restoreMode;
  logic [1:0] inService;
  logic [2:0] stackDepth, maskOut;

  logic       sAck, sRv, sOvf, sUdf;
  logic [7:0] sVec, sRa, sRm;
  logic [1:0] sIns;
  logic [1:0] sDepth;
  logic [2:0] sMask;

  irq_nest_ctrl i_irq_nest_ctrl (
    .clk(clk), .rstN(rstN), .irqLineN(irqLineN), .pinsAvail(pinsAvail),
    .intEnable(intEnable), .cfgWe(cfgWe), .cfgEdge(cfgEdge), .cfgNest(cfgNest),
    .forceClrWe(forceClrWe), .forceClrData(forceClrData), .maskWe(maskWe),
    .maskData(maskData), .arithStat(arithStat), .modeStat(modeStat),
    .rtiStrobe(rtiStrobe), .ack(ack), .vecAddr(vecAddr), .inService(inService),
    .stackDepth(stackDepth), .maskOut(maskOut), .restoreValid(restoreValid),
    .restoreArith(restoreArith), .restoreMode(restoreMode),
    .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  // same stimulus, two-entry stack to reach overflow
  irq_nest_ctrl #(.STACK_D(2)) i_irq_nest_ctrl_shallow (
    .clk(clk), .rstN(rstN), .irqLineN(irqLineN), .pinsAvail(pinsAvail),
    .intEnable(intEnable), .cfgWe(cfgWe), .cfgEdge(cfgEdge), .cfgNest(cfgNest),
    .forceClrWe(forceClrWe), .forceClrData(forceClrData), .maskWe(maskWe),
    .maskData(maskData), .arithStat(arithStat), .modeStat(modeStat),
    .rtiStrobe(rtiStrobe), .ack(sAck), .vecAddr(sVec), .inService(sIns),
    .stackDepth(sDepth), .maskOut(sMask), .restoreValid(sRv),
    .restoreArith(sRa), .restoreMode(sRm), .ovfFlag(sOvf), .udfFlag(sUdf)
  );

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // {req[14:12], mask[11:9], avail[8], en[7], expAck[6], expVec[5:0]}
  localparam logic [14:0] VEC_TAB [12] = '{
    {3'b001, 3'b111, 1'b1, 1'b1, 1'b1, 6'd0},
    {3'b010, 3'b111, 1'b1, 1'b1, 1'b1, 6'd4},
    {3'b100, 3'b111, 1'b1, 1'b1, 1'b1, 6'd8},
    {3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 6'd8},
    {3'b011, 3'b111, 1'b1, 1'b1, 1'b1, 6'd4},
    {3'b111, 3'b011, 1'b1, 1'b1, 1'b1, 6'd4},
    {3'b100, 3'b000, 1'b1, 1'b1, 1'b0, 6'd0},
    {3'b011, 3'b111, 1'b0, 1'b1, 1'b0, 6'd0},
    {3'b111, 3'b111, 1'b0, 1'b1, 1'b1, 6'd8},
    {3'b101, 3'b101, 1'b1, 1'b1, 1'b1, 6'd8},
    {3'b100, 3'b111, 1'b1, 1'b0, 1'b0, 6'd0},
    {3'b001, 3'b001, 1'b1, 1'b1, 1'b1, 6'd0}
  };

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset;
    rstN = 1'b0;
    irqLineN = 3'b111; pinsAvail = 1'b1; intEnable = 1'b1;
    cfgWe = 1'b0; cfgEdge = 3'b000; cfgNest = 1'b0;
    forceClrWe = 1'b0; forceClrData = '0; maskWe = 1'b0; maskData = '0;
    arithStat = '0; modeStat = '0; rtiStrobe = 1'b0;
    tick; tick;
    rstN = 1'b1;
  endtask

  task automatic setCfg(input logic [2:0] edg, input logic nest, input logic [2:0] m);
    cfgWe = 1'b1; cfgEdge = edg; cfgNest = nest; maskWe = 1'b1; maskData = m;
    tick;
    cfgWe = 1'b0; maskWe = 1'b0;
  endtask

  task automatic setMask(input logic [2:0] m);
    maskWe = 1'b1; maskData = m;
    tick;
    maskWe = 1'b0;
  endtask

  task automatic doRti;
    rtiStrobe = 1'b1;
    tick;
    rtiStrobe = 1'b0;
  endtask

  task automatic writeFc(input logic [5:0] d);
    forceClrWe = 1'b1; forceClrData = d;
    tick;
    forceClrWe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset;
    chk("R1 ack", ack, 0);
    chk("R1 vecAddr", vecAddr, 0);
    chk("R1 inService", inService, 0);
    chk("R1 stackDepth", stackDepth, 0);
    chk("R1 maskOut", maskOut, 0);
    chk("R1 restoreValid", restoreValid, 0);
    chk("R1 ovfFlag", ovfFlag, 0);
    chk("R1 udfFlag", udfFlag, 0);

    // R2 R5 R6 arbitration table
    for (int k = 0; k < 12; k++) begin
      logic [14:0] row;
      row = VEC_TAB[k];
      doReset;
      pinsAvail = row[8];
      intEnable = row[7];
      setCfg(3'b111, 1'b1, row[11:9]);
      irqLineN = ~row[14:12];
      tick; tick;
      chk($sformatf("R2 R5 R6 row%0d ack", k), ack, row[6]);
      if (row[6]) chk($sformatf("R2 row%0d vecAddr", k), vecAddr, row[5:0]);
      irqLineN = 3'b111;
      tick;
      chk($sformatf("R2 row%0d pulse", k), ack, 0);
    end

    // R4 level mode: masked low pulse leaves nothing
    doReset;
    setCfg(3'b101, 1'b0, 3'b000);
    irqLineN = 3'b101;
    tick; tick; tick;
    chk("R5 masked level", ack, 0);
    irqLineN = 3'b111;
    tick;
    setMask(3'b010);
    tick;
    chk("R4 level not latched", ack, 0);

    // R3 edge mode: masked falling edge stays pending
    setCfg(3'b111, 1'b0, 3'b000);
    irqLineN = 3'b101;
    tick; tick;
    irqLineN = 3'b111;
    tick;
    setMask(3'b010);
    tick;
    chk("R3 edge latched ack", ack, 1);
    chk("R3 edge latched vec", vecAddr, 4);
    doRti;
    tick; tick;
    chk("R3 cleared on accept", ack, 0);

    // R7 force / cancel
    doReset;
    setCfg(3'b111, 1'b0, 3'b111);
    writeFc(6'b000_010);
    tick;
    chk("R7 force ack", ack, 1);
    chk("R7 force vec", vecAddr, 4);
    doRti;
    setMask(3'b000);
    writeFc(6'b000_100);
    writeFc(6'b100_000);
    setMask(3'b111);
    tick;
    chk("R7 cancel", ack, 0);
    writeFc(6'b001_001);
    tick; tick;
    chk("R7 cancel wins", ack, 0);

    // R9 one at a time
    doReset;
    setCfg(3'b111, 1'b0, 3'b111);
    irqLineN = 3'b110;
    tick; tick;
    chk("R9 first ack", ack, 1);
    chk("R9 inService", inService, 1);
    irqLineN = 3'b011;
    tick;
    irqLineN = 3'b111;
    tick; tick;
    chk("R9 no accept in service", ack, 0);
    chk("R9 still level1", inService, 1);
    doRti;
    chk("R11 idle after return", inService, 0);
    chk("R11 depth after return", stackDepth, 0);
    chk("R11 ack blocked", ack, 0);
    tick;
    chk("R9 accept after return", ack, 1);
    chk("R9 vec after return", vecAddr, 8);

    // R8 R10 R11 R12 R13 nested stair
    doReset;
    setCfg(3'b111, 1'b1, 3'b111);
    arithStat = 8'h11; modeStat = 8'hA1;
    irqLineN = 3'b110;
    tick; tick;
    chk("R10 push1 ack", ack, 1);
    chk("R10 push1 depth", stackDepth, 1);
    chk("R10 push1 level", inService, 1);
    arithStat = 8'h22; modeStat = 8'hA2;
    irqLineN = 3'b101;
    tick; tick;
    chk("R8 preempt by 1 vec", vecAddr, 4);
    chk("R8 preempt by 1 ack", ack, 1);
    chk("R10 push2 depth", stackDepth, 2);
    arithStat = 8'h33; modeStat = 8'hA3;
    irqLineN = 3'b011;
    tick; tick;
    chk("R8 preempt by 2 ack", ack, 1);
    chk("R8 preempt by 2 vec", vecAddr, 8);
    chk("R10 push3 depth", stackDepth, 3);
    chk("R8 level3", inService, 3);
    chk("R12 main no ovf", ovfFlag, 0);
    chk("R12 shallow ovf", sOvf, 1);
    chk("R12 shallow depth kept", sDepth, 2);
    chk("R12 shallow still acked", sAck, 1);
    irqLineN = 3'b101;
    tick; tick;
    chk("R8 lower blocked", ack, 0);
    irqLineN = 3'b111;
    setMask(3'b001);
    chk("R11 mask changed", maskOut, 3'b001);
    doRti;
    chk("R11 restoreValid", restoreValid, 1);
    chk("R11 restoreArith", restoreArith, 8'h33);
    chk("R11 restoreMode", restoreMode, 8'hA3);
    chk("R11 mask restored", maskOut, 3'b111);
    chk("R11 depth", stackDepth, 2);
    chk("R11 level restored", inService, 2);
    tick;
    chk("R8 equal level blocked", ack, 0);
    chk("R11 valid one clock", restoreValid, 0);
    doRti;
    chk("R11 second restoreArith", restoreArith, 8'h22);
    chk("R11 second level", inService, 1);
    chk("R11 no ack on return", ack, 0);
    tick;
    chk("R8 reaccept after return", ack, 1);
    chk("R8 reaccept vec", vecAddr, 4);
    doRti;
    doRti;
    chk("R13 empty depth", stackDepth, 0);
    chk("R13 no udf yet", udfFlag, 0);
    doRti;
    chk("R13 udf set", udfFlag, 1);
    chk("R13 depth stays", stackDepth, 0);
    chk("R13 no restore", restoreValid, 0);
    chk("R13 shallow udf", sUdf, 1);
    tick;
    chk("R13 udf sticky", udfFlag, 1);
    chk("R12 ovf sticky", sOvf, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule